// File: doc/BRIEF.md
# Monitor-Detect Interrupt and Sense-Select Registers

This block holds two control registers for a display-link transmitter. A simple synchronous register bus reaches them: address, write data, write strobe and combinational read data. The block watches two external status levels, hot-plug and receiver-sense. It also watches a reference-level status input. All three pass through a two-flop synchronizer.

Software picks one of the two status inputs to watch. When that input changes level, a sticky monitor-detect flag drops to zero. Writing a one to the flag sets it back to one. A select field chooses what drives the monitor-sense output pin: the flag, one of the two status levels, or a constant high.

The second register holds two link control bits and the de-skew settings. The link control bits reach the link datapath only during blanking. The block also presents an effective de-skew code and an enable to the datapath.

Top module: `mon_sense_regs`

## Requirements
- R1: After reset, address 0x09 reads 0x00 when all status inputs are low, and address 0x0A reads 0x80. After reset the sense pin is high, the link control outputs are 00, the de-skew enable is low and the de-skew code is 100.
- R2: At address 0x09, bit 0 is the detect flag. The flag goes to 0 on the third rising clock edge after the monitored input pin changes level. The edge on which the synchronized level first differs from its stored previous value is the one that clears it.
- R3: A bus write to 0x09 with bit 0 = 1 sets the flag to 1 at that write edge. A write with bit 0 = 0 leaves the flag unchanged.
- R4: If a level-change detection and a write of 1 to the flag fall on the same edge, the flag becomes 0.
- R5: Bit 3 of 0x09 selects the monitored input: 0 watches receiver-sense, 1 watches hot-plug. A change on the input that is not selected leaves the flag unchanged.
- R6: A write that changes bit 3 does not by itself clear the flag, even when the two inputs are at different levels.
- R7: Bits 6:4 of 0x09 select the sense pin source. 000 gives high, 001 gives the flag, 010 gives synchronized receiver-sense, and 011 gives synchronized hot-plug. Codes 100 to 111 give high. The stored code reads back as written.
- R8: At 0x09, bit 1 shows hot-plug, bit 2 shows receiver-sense and bit 7 shows the reference-level status. Each bit is the synchronized input, visible two edges after the pin changes. Writes to these bits are ignored.
- R9: At 0x0A, bits 2:1 hold the link control pair, bit 4 the de-skew enable and bits 7:5 the de-skew step. Bits 0 and 3 read 0 and ignore writes.
- R10: The link control outputs carry bits 2:1 of 0x0A while data enable is low, and 00 while it is high.
- R11: With the de-skew enable set, the de-skew enable output is high and the code output equals the stored step (000 minimum setup to 111 maximum setup). With the enable clear, the enable output is low and the code output is 100.
- R12: Any other address reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| hpd_in | input | 1 | Hot-plug level, asynchronous |
| rsense_in | input | 1 | Receiver-sense level, asynchronous |
| vref_low_in | input | 1 | Reference-level status, asynchronous |
| de_in | input | 1 | Data enable; low during blanking |
| link_ctl_o | output | 2 | Link control pair toward the datapath |
| deskew_en_o | output | 1 | De-skew enable toward the datapath |
| deskew_code_o | output | 3 | Effective de-skew step code |
| msense_o | output | 1 | Monitor-sense pin |

## Verification
Each result has a fixed latency:

- Register writes, and the outputs that are pure functions of register state, settle at the write edge.
- Status bits follow a pin change two edges later.
- The detect flag, and a sense pin that shows the flag, fall on the third edge.

The driver changes pins and bus signals at the falling edge and queues each expectation for the next rising edge. The monitor compares one nanosecond after that edge. For pin changes the bench queues a check for every edge in between, so a result that comes one edge early or one edge late is caught.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int DATA_W    = 8;
  localparam int STEP_W    = 3;
  localparam int MSRC_W    = 3;
  localparam int NUM_STAT  = 3;

  localparam logic [STEP_W-1:0] STEP_RESET = 3'b100;

  // bit positions in the mode/status register
  localparam int B_FLAG  = 0;
  localparam int B_HPD   = 1;
  localparam int B_RSNS  = 2;
  localparam int B_TSEL  = 3;
  localparam int B_MSLO  = 4;
  localparam int B_VLOW  = 7;

  // bit positions in the link control register
  localparam int B_CTLLO = 1;
  localparam int B_DKEN  = 4;
  localparam int B_DKLO  = 5;

  typedef enum logic [MSRC_W-1:0] {
    MS_HIGH   = 3'd0,
    MS_FLAG   = 3'd1,
    MS_RSENSE = 3'd2,
    MS_HPD    = 3'd3
  } msense_src_e;

  typedef struct packed {
    logic hpd;
    logic rsense;
    logic vlow;
  } stat_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/msr_detect.sv
module msr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rsense_s,
  input  logic hpd_s,
  input  logic src_q,
  input  logic src_wr,
  input  logic src_new,
  input  logic clr_wr,
  output logic flag_o
);
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic mon_lvl, new_lvl, switching, change;

  always_comb begin
    mon_lvl   = src_q   ? hpd_s : rsense_s;
    new_lvl   = src_new ? hpd_s : rsense_s;
    switching = src_wr && (src_new != src_q);
    change    = !switching && (mon_lvl != prev_q);
    prev_d    = switching ? new_lvl : mon_lvl;
    if (change)      flag_d = 1'b0;
    else if (clr_wr) flag_d = 1'b1;
    else             flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R2 / R4: a seen level change always leaves the flag at zero
  assert_detect_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!switching && (mon_lvl != prev_q)) |=> !flag_o);

  // R3: a clear with no change sets the flag
  assert_clear_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !switching && (mon_lvl == prev_q)) |=> flag_o);

  // R6: a source switch without clear keeps the flag
  assert_switch_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (switching && !clr_wr) |=> $stable(flag_o));
endmodule

// File: rtl/msr_sense_mux.sv
module msr_sense_mux
  import msr_pkg::*;
#(
  parameter int SEL_W = MSRC_W
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             flag_i,
  input  logic             rsense_i,
  input  logic             hpd_i,
  output logic             pin_o
);
  always_comb begin
    case (sel_i)
      MS_FLAG:   pin_o = flag_i;
      MS_RSENSE: pin_o = rsense_i;
      MS_HPD:    pin_o = hpd_i;
      default:   pin_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/msr_link_ctl.sv
module msr_link_ctl
  import msr_pkg::*;
#(
  parameter int                CTL_W   = 2,
  parameter int                DK_W    = STEP_W,
  parameter logic [DK_W-1:0]   DK_INIT = STEP_RESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTL_W-1:0]  ctl_wd,
  input  logic              dken_wd,
  input  logic [DK_W-1:0]   dk_wd,
  input  logic              de_in,
  output logic [DATA_W-1:0] rd_o,
  output logic [CTL_W-1:0]  link_ctl_o,
  output logic              deskew_en_o,
  output logic [DK_W-1:0]   deskew_code_o
);
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic             dken_q, dken_d;
  logic [DK_W-1:0]  dk_q, dk_d;

  always_comb begin
    ctl_d  = wr_i ? ctl_wd  : ctl_q;
    dken_d = wr_i ? dken_wd : dken_q;
    dk_d   = wr_i ? dk_wd   : dk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      dken_q <= 1'b0;
      dk_q   <= DK_INIT;
    end else begin
      ctl_q  <= ctl_d;
      dken_q <= dken_d;
      dk_q   <= dk_d;
    end
  end

  always_comb begin
    rd_o = '0;
    rd_o[B_CTLLO +: CTL_W] = ctl_q;
    rd_o[B_DKEN]           = dken_q;
    rd_o[B_DKLO +: DK_W]   = dk_q;
  end

  assign link_ctl_o    = de_in  ? '0   : ctl_q;
  assign deskew_en_o   = dken_q;
  assign deskew_code_o = dken_q ? dk_q : DK_INIT;

  // R10: written pair reaches the link during blanking
  assert_ctl_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (de_in || (link_ctl_o == $past(ctl_wd))));

  // R11: disabled de-skew presents the default step
  assert_dk_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !dken_wd) |=> (!deskew_en_o && (deskew_code_o == DK_INIT)));

  // R11: enabled de-skew presents the written step
  assert_dk_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && dken_wd) |=> (deskew_en_o && (deskew_code_o == $past(dk_wd))));
endmodule

// File: rtl/mon_sense_regs.sv
module mon_sense_regs
  import msr_pkg::*;
#(
  parameter int                 ADDR_W      = 8,
  parameter int                 SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0]  MODE_ADDR   = 8'h09,
  parameter logic [ADDR_W-1:0]  LINK_ADDR   = 8'h0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hpd_in,
  input  logic              rsense_in,
  input  logic              vref_low_in,
  input  logic              de_in,
  output logic [1:0]        link_ctl_o,
  output logic              deskew_en_o,
  output logic [STEP_W-1:0] deskew_code_o,
  output logic              msense_o
);
  localparam int CTL_W = 2;

  stat_t              raw, stat_s;
  logic               mode_wr, link_wr;
  logic               tsel_q, tsel_d;
  logic [MSRC_W-1:0]  msel_q, msel_d;
  logic               flag;
  logic [DATA_W-1:0]  mode_rd, link_rd;

  assign raw = '{hpd: hpd_in, rsense: rsense_in, vlow: vref_low_in};

  msr_sync #(.WIDTH(NUM_STAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (raw),
    .sync_o (stat_s)
  );

  assign mode_wr = reg_we && (reg_addr == MODE_ADDR);
  assign link_wr = reg_we && (reg_addr == LINK_ADDR);

  always_comb begin
    tsel_d = mode_wr ? reg_wdata[B_TSEL]             : tsel_q;
    msel_d = mode_wr ? reg_wdata[B_MSLO +: MSRC_W]   : msel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q <= 1'b0;
      msel_q <= '0;
    end else begin
      tsel_q <= tsel_d;
      msel_q <= msel_d;
    end
  end

  msr_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsense_s (stat_s.rsense),
    .hpd_s    (stat_s.hpd),
    .src_q    (tsel_q),
    .src_wr   (mode_wr),
    .src_new  (reg_wdata[B_TSEL]),
    .clr_wr   (mode_wr && reg_wdata[B_FLAG]),
    .flag_o   (flag)
  );

  msr_sense_mux u_mux (
    .sel_i    (msel_q),
    .flag_i   (flag),
    .rsense_i (stat_s.rsense),
    .hpd_i    (stat_s.hpd),
    .pin_o    (msense_o)
  );

  msr_link_ctl #(.CTL_W(CTL_W)) u_link (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (link_wr),
    .ctl_wd        (reg_wdata[B_CTLLO +: CTL_W]),
    .dken_wd       (reg_wdata[B_DKEN]),
    .dk_wd         (reg_wdata[B_DKLO +: STEP_W]),
    .de_in         (de_in),
    .rd_o          (link_rd),
    .link_ctl_o    (link_ctl_o),
    .deskew_en_o   (deskew_en_o),
    .deskew_code_o (deskew_code_o)
  );

  always_comb begin
    mode_rd = '0;
    mode_rd[B_FLAG]            = flag;
    mode_rd[B_HPD]             = stat_s.hpd;
    mode_rd[B_RSNS]            = stat_s.rsense;
    mode_rd[B_TSEL]            = tsel_q;
    mode_rd[B_MSLO +: MSRC_W]  = msel_q;
    mode_rd[B_VLOW]            = stat_s.vlow;
  end

  always_comb begin
    if (reg_addr == MODE_ADDR)      reg_rdata = mode_rd;
    else if (reg_addr == LINK_ADDR) reg_rdata = link_rd;
    else                            reg_rdata = '0;
  end

  // R7: codes off the defined set drive the pin high
  assert_msense_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && ((reg_wdata[B_MSLO +: MSRC_W] == 3'd0) || reg_wdata[B_MSLO + 2]))
      |=> msense_o);

  // R12: writes elsewhere leave the mode register alone
  assert_other_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr != MODE_ADDR)) |=> ($stable(tsel_q) && $stable(msel_q)));
endmodule

// File: tb/mon_sense_regs_tb.sv
`timescale 1ns/1ps
module mon_sense_regs_tb;
  localparam real HALF = 2.0;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_we, hpd_in, rsense_in, vref_low_in, de_in;
  logic [1:0] link_ctl_o;
  logic       deskew_en_o, msense_o;
  logic [2:0] deskew_code_o;

  always #(HALF) clk = ~clk;

  mon_sense_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .hpd_in(hpd_in),
    .rsense_in(rsense_in), .vref_low_in(vref_low_in), .de_in(de_in),
    .link_ctl_o(link_ctl_o), .deskew_en_o(deskew_en_o),
    .deskew_code_o(deskew_code_o), .msense_o(msense_o)
  );

  typedef struct {
    int         kind;   // 0 rdata, 1 msense, 2 link, 3 dk en, 4 dk code
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(int kind, logic [7:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
    reg_addr = a;
    chk(0, exp, tag);
    tick();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor: compare one ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = reg_rdata;
          1: act = {7'd0, msense_o};
          2: act = {6'd0, link_ctl_o};
          3: act = {7'd0, deskew_en_o};
          default: act = {5'd0, deskew_code_o};
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h",
                   it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00; reg_we = 1'b0;
    hpd_in = 1'b0; rsense_in = 1'b0; vref_low_in = 1'b0; de_in = 1'b0;
    wait_n(3);
    rst_n = 1'b1;

    // R1 reset state
    chk(1, 8'h01, "R1 msense");
    chk(2, 8'h00, "R1 link");
    chk(3, 8'h00, "R1 dken");
    chk(4, 8'h04, "R1 dkcode");
    rd(8'h09, 8'h00, "R1 mode");
    rd(8'h0A, 8'h80, "R1 link reg");

    // R3 set flag, write of zero keeps it
    wr(8'h09, 8'h01);
    rd(8'h09, 8'h01, "R3 set");
    wr(8'h09, 8'h00);
    rd(8'h09, 8'h01, "R3 zero write");

    // R5 unselected hot-plug change ignored; R8 status visible
    hpd_in = 1'b1;
    wait_n(4);
    rd(8'h09, 8'h03, "R5 unselected");

    // R2 / R8 receiver-sense change, edge-exact
    rsense_in = 1'b1;
    rd(8'h09, 8'h03, "R8 before sync");
    rd(8'h09, 8'h07, "R2 edge2 flag held");
    rd(8'h09, 8'h06, "R2 edge3 flag low");

    // R3 clear
    wr(8'h09, 8'h01);
    rd(8'h09, 8'h07, "R3 clear");

    // R4 change and clear on the same edge
    rsense_in = 1'b0;
    wait_n(2);
    wr(8'h09, 8'h01);
    rd(8'h09, 8'h02, "R4 detect wins");

    // R6 source switch with different levels
    wr(8'h09, 8'h01);
    rd(8'h09, 8'h03, "R3 clear again");
    wr(8'h09, 8'h08);
    rd(8'h09, 8'h0B, "R6 switch");
    wait_n(3);
    rd(8'h09, 8'h0B, "R6 switch later");

    // R2 / R5 hot-plug now monitored
    hpd_in = 1'b0;
    tick();
    rd(8'h09, 8'h09, "R2 hpd edge2");
    rd(8'h09, 8'h08, "R5 hpd edge3");
    wr(8'h09, 8'h09);
    rd(8'h09, 8'h09, "R3 clear tsel1");
    rsense_in = 1'b1;
    wait_n(4);
    rd(8'h09, 8'h0D, "R5 rsense ignored");

    // R7 sense pin sources
    wr(8'h09, 8'h19);
    chk(1, 8'h01, "R7 flag high"); tick();
    hpd_in = 1'b1;
    tick();
    chk(1, 8'h01, "R7 flag edge2"); tick();
    chk(1, 8'h00, "R7 flag edge3"); tick();
    wr(8'h09, 8'h29);
    chk(1, 8'h01, "R7 rsense high"); tick();
    rsense_in = 1'b0;
    chk(1, 8'h01, "R7 rsense edge1"); tick();
    chk(1, 8'h00, "R7 rsense edge2"); tick();
    wr(8'h09, 8'h39);
    chk(1, 8'h01, "R7 hpd high"); tick();
    hpd_in = 1'b0;
    chk(1, 8'h01, "R7 hpd edge1"); tick();
    chk(1, 8'h00, "R7 hpd edge2"); tick();
    wait_n(4);
    wr(8'h09, 8'h09);
    chk(1, 8'h01, "R7 code0"); tick();
    wr(8'h09, 8'h59);
    chk(1, 8'h01, "R7 code5");
    rd(8'h09, 8'h59, "R7 readback");

    // R8 read-only bits ignore writes, reference level live
    wr(8'h09, 8'hFF);
    rd(8'h09, 8'h79, "R8 ro write");
    vref_low_in = 1'b1;
    rd(8'h09, 8'h79, "R8 vref edge1");
    rd(8'h09, 8'hF9, "R8 vref edge2");

    // R9 / R10 / R11 link register
    wr(8'h0A, 8'hFF);
    rd(8'h0A, 8'hF6, "R9 all ones");
    chk(2, 8'h03, "R10 blank");
    chk(3, 8'h01, "R11 en");
    chk(4, 8'h07, "R11 max"); tick();
    de_in = 1'b1;
    chk(2, 8'h00, "R10 active"); tick();
    de_in = 1'b0;
    wr(8'h0A, 8'h42);
    rd(8'h0A, 8'h42, "R9 readback");
    chk(2, 8'h01, "R10 pair01");
    chk(3, 8'h00, "R11 off");
    chk(4, 8'h04, "R11 off code"); tick();
    wr(8'h0A, 8'h14);
    chk(2, 8'h02, "R10 pair10");
    chk(3, 8'h01, "R11 en min");
    chk(4, 8'h00, "R11 min"); tick();
    wr(8'h0A, 8'h09);
    rd(8'h0A, 8'h00, "R9 reserved");
    wr(8'h0A, 8'h14);

    // R12 other addresses
    rd(8'h05, 8'h00, "R12 read");
    wr(8'h05, 8'hFF);
    rd(8'h09, 8'hF9, "R12 mode kept");
    rd(8'h0A, 8'h14, "R12 link kept");

    wait_n(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule